// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a cache and the next level of memory and parks outgoing stores so that loads reach memory first. The cache hands a store over on the store port, and the store is complete for the cache as soon as it is accepted. Each held entry keeps a word address, a data word and a byte-enable mask. The buffer then writes its entries out, oldest first, over a shared memory request port in the cycles when that port has no load to carry.

Every load the cache presents is compared against all held entries. If the youngest entry at that address has all byte enables set, the load is answered from the buffer in the same cycle and never reaches memory. If it covers only some bytes, the load waits while the buffer drains until that entry has left, and then it goes to memory. If no entry matches, the load takes the memory port ahead of any pending write. A store to an address that is already held folds into that entry under its byte mask instead of using a new slot. When every slot is taken, the store port stops accepting and writes drain even if a load is waiting, so the buffer always makes progress. Read data coming back from memory returns to the cache on a path outside this block.

Top module: `storeBuffer`

## Requirements
- R1: After reset the buffer is empty: stReady is 1, memReqValid is 0, ldReady is 0 and ldFwd is 0.
- R2: A store is accepted in a cycle where stValid and stReady are both 1. stReady is 0 exactly when DEPTH entries are held, and a store offered while stReady is 0 leaves no trace in the buffer.
- R3: Held entries are written to memory oldest first. A write request has memReqWrite = 1 and carries the entry's address, data and byte mask (bit b of the mask enables data bits 8b+7..8b). An entry leaves when memReqValid, memReqWrite and memReqReady are all 1.
- R4: A load that matches no held entry, while the buffer is not full, drives memReqValid = 1, memReqWrite = 0 and memReqAddr = ldAddr with zero data and mask, and ldReady then equals memReqReady.
- R5: No write request is made in a cycle where a non-matching load is waiting and the buffer is not full.
- R6: A load whose youngest matching entry has all mask bits set gets ldFwd = 1, ldReady = 1 and ldData equal to that entry's data in the same cycle, with no read on the memory port. ldData is 0 whenever ldFwd is 0.
- R7: A load whose matching entry has only some mask bits set keeps ldReady = 0 and makes no memory read. Entries drain until that entry is gone, and only then does the load issue its read.
- R8: A store to a held address updates only the bytes its mask enables, ORs its mask into the entry's mask, and does not use a new slot.
- R9: When the buffer is full, a write request is made every cycle, even while a non-matching load waits. That load gets its read only once a slot has been freed.
- R10: A store whose address matches the oldest entry, in the same cycle that entry is written out, takes a new slot with only its own bytes and mask.
- R11: A load sees only the stores accepted before its cycle. A store accepted in the same cycle is not visible to it.
- R12: While memReqReady is 0, a pending write request keeps the same address in the next cycle in which a write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stValid | input | 1 | Store offered |
| stAddr | input | AW | Store word address |
| stData | input | DW | Store data |
| stMask | input | DW/8 | Store byte enables |
| stReady | output | 1 | Store can be accepted (buffer not full) |
| ldValid | input | 1 | Load lookup offered |
| ldAddr | input | AW | Load word address |
| ldReady | output | 1 | Load is done this cycle (forwarded or read accepted) |
| ldFwd | output | 1 | Load answered from the buffer |
| ldData | output | DW | Forwarded load data |
| memReqValid | output | 1 | Memory request valid |
| memReqWrite | output | 1 | 1 = write from buffer, 0 = load read |
| memReqAddr | output | AW | Memory request address |
| memReqData | output | DW | Write data |
| memReqMask | output | DW/8 | Write byte enables |
| memReqReady | input | 1 | Memory accepts the request |

## Verification
Loads are applied against an empty buffer, against entries with full byte coverage, against entries with partial coverage and against a full buffer. These four cases separate forwarding, read priority, the forced drain and the progress rule. Stores that fall on a held address are applied both while that entry stays and while it is leaving. The drained mask and data then show whether the store was folded in or given a new slot. A load paired with a same-cycle store to its own address checks that lookup uses only the state from before that cycle, and stalling memReqReady while full checks that the oldest entry stays in place and keeps its order.

// File: rtl/storeBufPkg.sv
package storeBufPkg;

  // control -> datapath write strobes
  typedef struct packed {
    logic alloc;   // write a new entry at the tail slot
    logic merge;   // fold the store into the youngest matching entry
  } strobeT;

  // datapath -> control lookup results
  typedef struct packed {
    logic ldHit;      // some live entry matches the load address
    logic ldFull;     // youngest load match has every byte enabled
    logic stHit;      // some live entry matches the store address
    logic stHitHead;  // youngest store match is the oldest entry
  } matchT;

endpackage

// File: rtl/storeBufData.sv
module storeBufData
  import storeBufPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int MW    = DW / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic [PTR_W-1:0] headIdx,
  input  logic [PTR_W-1:0] tailIdx,
  input  logic [DEPTH-1:0] liveVec,
  input  logic [AW-1:0]    stAddr,
  input  logic [DW-1:0]    stData,
  input  logic [MW-1:0]    stMask,
  input  logic [AW-1:0]    ldAddr,
  output matchT            match,
  output logic [DW-1:0]    fwdData,
  output logic [AW-1:0]    headAddr,
  output logic [DW-1:0]    headData,
  output logic [MW-1:0]    headMask
);

  logic [AW-1:0] entAddr [DEPTH];
  logic [DW-1:0] entData [DEPTH];
  logic [MW-1:0] entMask [DEPTH];

  logic [DEPTH-1:0] ldMatchVec;
  logic [DEPTH-1:0] stMatchVec;
  logic [PTR_W-1:0] ldSel;
  logic [PTR_W-1:0] stSel;
  logic             ldAny;
  logic             stAny;
  logic [DW-1:0]    mergedData;

  // per-entry address compare, gated by liveness
  for (genvar i = 0; i < DEPTH; i++) begin : gCmp
    assign ldMatchVec[i] = liveVec[i] && (entAddr[i] == ldAddr);
    assign stMatchVec[i] = liveVec[i] && (entAddr[i] == stAddr);
  end

  // walk from oldest to youngest, last match wins (youngest) - R6, R10
  always_comb begin
    ldAny = 1'b0;
    stAny = 1'b0;
    ldSel = headIdx;
    stSel = headIdx;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PTR_W-1:0] idx;
      idx = headIdx + PTR_W'(k);
      if (ldMatchVec[idx]) begin
        ldAny = 1'b1;
        ldSel = idx;
      end
      if (stMatchVec[idx]) begin
        stAny = 1'b1;
        stSel = idx;
      end
    end
  end

  // byte-lane merge of the store into its target entry - R8
  for (genvar b = 0; b < MW; b++) begin : gLane
    assign mergedData[8*b +: 8] = stMask[b] ? stData[8*b +: 8]
                                            : entData[stSel][8*b +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        entAddr[i] <= '0;
        entData[i] <= '0;
        entMask[i] <= '0;
      end
    end else begin
      if (strb.alloc) begin
        entAddr[tailIdx] <= stAddr;
        entData[tailIdx] <= stData;
        entMask[tailIdx] <= stMask;
      end else if (strb.merge) begin
        entData[stSel] <= mergedData;
        entMask[stSel] <= entMask[stSel] | stMask;
      end
    end
  end

  assign match.ldHit     = ldAny;
  assign match.ldFull    = &entMask[ldSel];
  assign match.stHit     = stAny;
  assign match.stHitHead = (stSel == headIdx);

  assign fwdData  = entData[ldSel];
  assign headAddr = entAddr[headIdx];
  assign headData = entData[headIdx];
  assign headMask = entMask[headIdx];

endmodule

// File: rtl/storeBufCtrl.sv
module storeBufCtrl
  import storeBufPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             ldValid,
  input  logic             memReqReady,
  input  matchT            match,
  output strobeT           strb,
  output logic [PTR_W-1:0] headIdx,
  output logic [PTR_W-1:0] tailIdx,
  output logic [DEPTH-1:0] liveVec,
  output logic             stReady,
  output logic             ldReady,
  output logic             ldFwd,
  output logic             memReqValid,
  output logic             memReqWrite
);

  logic [CNT_W-1:0] count;
  logic full;
  logic empty;
  logic fwdOk;
  logic readReq;
  logic drainReq;
  logic pop;
  logic stAcc;
  logic doMerge;
  logic doAlloc;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  // liveness by age relative to the oldest slot
  for (genvar i = 0; i < DEPTH; i++) begin : gLive
    logic [PTR_W-1:0] age;
    assign age        = PTR_W'(i) - headIdx;
    assign liveVec[i] = ({1'b0, age} < count);
  end

  // port arbitration: loads first, writes when the port is free or full - R4 R5 R9
  assign fwdOk    = ldValid && match.ldHit && match.ldFull;               // R6
  assign readReq  = ldValid && !match.ldHit && !full;                     // R4
  assign drainReq = !empty && !readReq;                                   // R5 R7 R9
  assign pop      = drainReq && memReqReady;                              // R3

  assign memReqValid = readReq || drainReq;
  assign memReqWrite = drainReq;
  assign ldFwd       = fwdOk;
  assign ldReady     = fwdOk || (readReq && memReqReady);

  // store side: merge unless the target is leaving this cycle - R8 R10
  assign stReady = !full;                                                 // R2
  assign stAcc   = stValid && !full;
  assign doMerge = stAcc && match.stHit && !(pop && match.stHitHead);
  assign doAlloc = stAcc && !doMerge;

  assign strb.alloc = doAlloc;
  assign strb.merge = doMerge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      headIdx <= '0;
      tailIdx <= '0;
    end else begin
      if (pop)     headIdx <= headIdx + 1'b1;
      if (doAlloc) tailIdx <= tailIdx + 1'b1;
      case ({doAlloc, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/storeBuffer.sv
module storeBuffer
  import storeBufPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stValid,
  input  logic [AW-1:0]   stAddr,
  input  logic [DW-1:0]   stData,
  input  logic [DW/8-1:0] stMask,
  output logic            stReady,
  input  logic            ldValid,
  input  logic [AW-1:0]   ldAddr,
  output logic            ldReady,
  output logic            ldFwd,
  output logic [DW-1:0]   ldData,
  output logic            memReqValid,
  output logic            memReqWrite,
  output logic [AW-1:0]   memReqAddr,
  output logic [DW-1:0]   memReqData,
  output logic [DW/8-1:0] memReqMask,
  input  logic            memReqReady
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int MW    = DW / 8;

  strobeT           strb;
  matchT            match;
  logic [PTR_W-1:0] headIdx;
  logic [PTR_W-1:0] tailIdx;
  logic [DEPTH-1:0] liveVec;
  logic [DW-1:0]    fwdData;
  logic [AW-1:0]    headAddr;
  logic [DW-1:0]    headData;
  logic [MW-1:0]    headMask;

  storeBufCtrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .stValid    (stValid),
    .ldValid    (ldValid),
    .memReqReady(memReqReady),
    .match      (match),
    .strb       (strb),
    .headIdx    (headIdx),
    .tailIdx    (tailIdx),
    .liveVec    (liveVec),
    .stReady    (stReady),
    .ldReady    (ldReady),
    .ldFwd      (ldFwd),
    .memReqValid(memReqValid),
    .memReqWrite(memReqWrite)
  );

  storeBufData #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PTR_W(PTR_W), .MW(MW)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .headIdx (headIdx),
    .tailIdx (tailIdx),
    .liveVec (liveVec),
    .stAddr  (stAddr),
    .stData  (stData),
    .stMask  (stMask),
    .ldAddr  (ldAddr),
    .match   (match),
    .fwdData (fwdData),
    .headAddr(headAddr),
    .headData(headData),
    .headMask(headMask)
  );

  // memory port mux: write carries the oldest entry, read carries the load - R3 R4
  assign memReqAddr = memReqWrite ? headAddr : ldAddr;
  assign memReqData = memReqWrite ? headData : '0;
  assign memReqMask = memReqWrite ? headMask : '0;
  assign ldData     = ldFwd ? fwdData : '0;                              // R6

endmodule

// File: rtl/storeBufChecker.sv
module storeBufChecker #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          stReady,
  input logic          ldValid,
  input logic [AW-1:0] ldAddr,
  input logic          ldReady,
  input logic          ldFwd,
  input logic [DW-1:0] ldData,
  input logic          memReqValid,
  input logic          memReqWrite,
  input logic [AW-1:0] memReqAddr,
  input logic          memReqReady
);

  AST_READ_IS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite) |-> (ldValid && memReqAddr == ldAddr && stReady)); // R4

  AST_LD_DONE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ldReady |-> ldValid); // R4

  AST_FULL_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (!stReady) |-> (memReqValid && memReqWrite)); // R9

  AST_FWD_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    ldFwd |-> (ldReady && !(memReqValid && !memReqWrite))); // R6

  AST_NO_FWD_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (!ldFwd) |-> (ldData == '0)); // R6

  AST_STALL_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && !memReqReady)
      |=> (!(memReqValid && memReqWrite) || $stable(memReqAddr))); // R12

endmodule

bind storeBuffer storeBufChecker #(.AW(AW), .DW(DW)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .stReady    (stReady),
  .ldValid    (ldValid),
  .ldAddr     (ldAddr),
  .ldReady    (ldReady),
  .ldFwd      (ldFwd),
  .ldData     (ldData),
  .memReqValid(memReqValid),
  .memReqWrite(memReqWrite),
  .memReqAddr (memReqAddr),
  .memReqReady(memReqReady)
);

// File: tb/tb_storeBuffer.sv
module tb_storeBuffer;

  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int MW    = DW / 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          stValid = 1'b0;
  logic [AW-1:0] stAddr = '0;
  logic [DW-1:0] stData = '0;
  logic [MW-1:0] stMask = '0;
  logic          stReady;
  logic          ldValid = 1'b0;
  logic [AW-1:0] ldAddr = '0;
  logic          ldReady;
  logic          ldFwd;
  logic [DW-1:0] ldData;
  logic          memReqValid;
  logic          memReqWrite;
  logic [AW-1:0] memReqAddr;
  logic [DW-1:0] memReqData;
  logic [MW-1:0] memReqMask;
  logic          memReqReady = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  always #2ns clk = ~clk;

  storeBuffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rstN(rstN),
    .stValid(stValid), .stAddr(stAddr), .stData(stData), .stMask(stMask), .stReady(stReady),
    .ldValid(ldValid), .ldAddr(ldAddr), .ldReady(ldReady), .ldFwd(ldFwd), .ldData(ldData),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqData(memReqData), .memReqMask(memReqMask), .memReqReady(memReqReady)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check combinational outputs 1 ns later
  task automatic drive(input logic sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                       input logic [MW-1:0] sm, input logic lv, input logic [AW-1:0] la,
                       input logic rdy);
    @(negedge clk);
    stValid = sv; stAddr = sa; stData = sd; stMask = sm;
    ldValid = lv; ldAddr = la; memReqReady = rdy;
    #1ns;
  endtask

  typedef struct packed {
    logic          stV;
    logic [15:0]   stA;
    logic [31:0]   stD;
    logic [3:0]    stM;
    logic          ldV;
    logic [15:0]   ldA;
    logic          rdy;
    logic          eMv;
    logic          eMw;
    logic [15:0]   eAddr;
    logic [31:0]   eData;
    logic [3:0]    eMask;
    logic          eLdR;
    logic          eFwd;
    logic [31:0]   eLdD;
    logic          eStR;
  } vecT;

  localparam int NV = 13;
  localparam vecT VEC [NV] = '{
    // R2: store 0x10 into empty buffer, port idle
    '{1'b1, 16'h0010, 32'h11111111, 4'hF, 1'b0, 16'h0000, 1'b0,
      1'b0, 1'b0, 16'h0000, 32'h0, 4'h0, 1'b0, 1'b0, 32'h0, 1'b1},
    // R6: load 0x10 forwarded; R5 write allowed since load is served; store 0x20 partial
    '{1'b1, 16'h0020, 32'h22222222, 4'h3, 1'b1, 16'h0010, 1'b0,
      1'b1, 1'b1, 16'h0010, 32'h11111111, 4'hF, 1'b1, 1'b1, 32'h11111111, 1'b1},
    // R4 R5: miss load wins port; R8 store merges upper bytes into 0x10
    '{1'b1, 16'h0010, 32'hAABBCCDD, 4'hC, 1'b1, 16'h0030, 1'b1,
      1'b1, 1'b0, 16'h0030, 32'h0, 4'h0, 1'b1, 1'b0, 32'h0, 1'b1},
    // R8: merged value forwarded
    '{1'b0, 16'h0000, 32'h0, 4'h0, 1'b1, 16'h0010, 1'b0,
      1'b1, 1'b1, 16'h0010, 32'hAABB1111, 4'hF, 1'b1, 1'b1, 32'hAABB1111, 1'b1},
    // R7: partial match on 0x20, oldest (0x10) drains first, R3 order
    '{1'b0, 16'h0000, 32'h0, 4'h0, 1'b1, 16'h0020, 1'b1,
      1'b1, 1'b1, 16'h0010, 32'hAABB1111, 4'hF, 1'b0, 1'b0, 32'h0, 1'b1},
    // R7: still waiting, 0x20 drains with its mask
    '{1'b0, 16'h0000, 32'h0, 4'h0, 1'b1, 16'h0020, 1'b1,
      1'b1, 1'b1, 16'h0020, 32'h22222222, 4'h3, 1'b0, 1'b0, 32'h0, 1'b1},
    // R7: entry gone, load now reads memory
    '{1'b0, 16'h0000, 32'h0, 4'h0, 1'b1, 16'h0020, 1'b1,
      1'b1, 1'b0, 16'h0020, 32'h0, 4'h0, 1'b1, 1'b0, 32'h0, 1'b1},
    // R11: same-cycle store to 0x40 not seen by load -> read, memory stalled
    '{1'b1, 16'h0040, 32'h44444444, 4'hF, 1'b1, 16'h0040, 1'b0,
      1'b1, 1'b0, 16'h0040, 32'h0, 4'h0, 1'b0, 1'b0, 32'h0, 1'b1},
    // R11: next cycle it is forwarded
    '{1'b0, 16'h0000, 32'h0, 4'h0, 1'b1, 16'h0040, 1'b0,
      1'b1, 1'b1, 16'h0040, 32'h44444444, 4'hF, 1'b1, 1'b1, 32'h44444444, 1'b1},
    // R10: store 0x40 while 0x40 drains -> new slot
    '{1'b1, 16'h0040, 32'h55555555, 4'h1, 1'b0, 16'h0000, 1'b1,
      1'b1, 1'b1, 16'h0040, 32'h44444444, 4'hF, 1'b0, 1'b0, 32'h0, 1'b1},
    // R10: new entry holds only its own mask
    '{1'b0, 16'h0000, 32'h0, 4'h0, 1'b0, 16'h0000, 1'b0,
      1'b1, 1'b1, 16'h0040, 32'h55555555, 4'h1, 1'b0, 1'b0, 32'h0, 1'b1},
    // R7: partial load drains it
    '{1'b0, 16'h0000, 32'h0, 4'h0, 1'b1, 16'h0040, 1'b1,
      1'b1, 1'b1, 16'h0040, 32'h55555555, 4'h1, 1'b0, 1'b0, 32'h0, 1'b1},
    // R3: empty again, port idle
    '{1'b0, 16'h0000, 32'h0, 4'h0, 1'b0, 16'h0000, 1'b1,
      1'b0, 1'b0, 16'h0000, 32'h0, 4'h0, 1'b0, 1'b0, 32'h0, 1'b1}
  };

  initial begin
    #(4ns * 200000);
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1ns;
    // R1 reset state
    chk("R1", "stReady", 64'(stReady), 64'd1);
    chk("R1", "memReqValid", 64'(memReqValid), 64'd0);
    chk("R1", "ldReady", 64'(ldReady), 64'd0);
    chk("R1", "ldFwd", 64'(ldFwd), 64'd0);
    rstN = 1'b1;

    // vector table
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v].stV, VEC[v].stA, VEC[v].stD, VEC[v].stM, VEC[v].ldV, VEC[v].ldA, VEC[v].rdy);
      chk("R5", "memReqValid", 64'(memReqValid), 64'(VEC[v].eMv));
      if (VEC[v].eMv) begin
        chk("R4", "memReqWrite", 64'(memReqWrite), 64'(VEC[v].eMw));
        chk("R3", "memReqAddr", 64'(memReqAddr), 64'(VEC[v].eAddr));
        chk("R3", "memReqData", 64'(memReqData), 64'(VEC[v].eData));
        chk("R3", "memReqMask", 64'(memReqMask), 64'(VEC[v].eMask));
      end
      chk("R6", "ldReady", 64'(ldReady), 64'(VEC[v].eLdR));
      chk("R6", "ldFwd", 64'(ldFwd), 64'(VEC[v].eFwd));
      chk("R6", "ldData", 64'(ldData), 64'(VEC[v].eLdD));
      chk("R2", "stReady", 64'(stReady), 64'(VEC[v].eStR));
    end

    // R2: fill all slots with memory stalled
    for (int i = 0; i < DEPTH; i++) begin
      drive(1'b1, AW'(16'h0100 + i), {16'hD0D0, 16'(16'h0100 + i)}, 4'hF, 1'b0, '0, 1'b0);
      chk("R2", "stReady while filling", 64'(stReady), 64'd1);
    end
    // full: extra store offered (must be dropped), miss load waits - R9
    drive(1'b1, 16'h0300, 32'hDEADBEEF, 4'hF, 1'b1, 16'h0200, 1'b0);
    chk("R2", "stReady when full", 64'(stReady), 64'd0);
    chk("R9", "write while full", 64'({memReqValid, memReqWrite}), 64'd3);
    chk("R9", "head addr", 64'(memReqAddr), 64'h0100);
    chk("R9", "load waits", 64'(ldReady), 64'd0);
    drive(1'b1, 16'h0300, 32'hDEADBEEF, 4'hF, 1'b1, 16'h0200, 1'b0);
    chk("R12", "stalled addr held", 64'(memReqAddr), 64'h0100);
    chk("R12", "stalled still write", 64'(memReqWrite), 64'd1);
    drive(1'b1, 16'h0300, 32'hDEADBEEF, 4'hF, 1'b1, 16'h0200, 1'b1);
    chk("R9", "drain despite load", 64'({memReqValid, memReqWrite}), 64'd3);
    chk("R9", "load still waits", 64'(ldReady), 64'd0);
    drive(1'b0, '0, '0, '0, 1'b1, 16'h0200, 1'b1);
    chk("R9", "slot freed stReady", 64'(stReady), 64'd1);
    chk("R4", "read gets port", 64'({memReqValid, memReqWrite}), 64'd2);
    chk("R4", "read addr", 64'(memReqAddr), 64'h0200);
    chk("R4", "read done", 64'(ldReady), 64'd1);
    // R3: remaining entries drain in order
    for (int i = 1; i < DEPTH; i++) begin
      drive(1'b0, '0, '0, '0, 1'b0, '0, 1'b1);
      chk("R3", "drain write", 64'({memReqValid, memReqWrite}), 64'd3);
      chk("R3", "drain addr", 64'(memReqAddr), 64'(16'h0100 + i));
      chk("R3", "drain data", 64'(memReqData), 64'({16'hD0D0, 16'(16'h0100 + i)}));
    end
    // R2: the store offered while full never entered
    drive(1'b0, '0, '0, '0, 1'b0, '0, 1'b1);
    chk("R2", "empty after drain", 64'(memReqValid), 64'd0);

    doneFlag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule